// File: doc/BRIEF.md
# Strided Lane Load-Store Address Generator

This block sits in one lane of a multi-lane vector unit and carries out vector load and store instructions against that lane's own private memory bank. Each instruction arrives as two 32-bit words over a valid/ready channel. The first word names the vector register, the store/load direction, the address stride and the total vector length. The second word gives the base address in the bank. Once both words are in, the unit steps through the lane's share of the elements and issues one access per clock, with no pause.

The bank is private to the lane and never refuses an access, so there is no back-pressure on the memory side. A store reads each element through a single register-file read port and writes it to the bank one cycle later. A load reads the bank and hands the returned word to a register-file write port one cycle later. A one-cycle done pulse marks the last element. After that pulse the command channel opens again.

Top module: `lane_strided_agu`

## Requirements
- R1: Instruction word fields: bits [7:0] register ID, bits [15:8] unsigned stride, bits [23:16] total vector length, and bit 31 set for a store or clear for a load. Bits [30:24] are ignored. The base word follows and supplies the base address in its low 16 bits; its upper bits are ignored. No access starts until the base word has been accepted, however long the gap between the two words.
- R2: The number of elements moved equals the total vector length divided by the lane count (4), rounded down.
- R3: Element n uses address base + n*stride modulo 2^16. This holds for stride 0, stride 1 and strides that wrap past the top of the bank.
- R4: A load asserts mem_rd with element n's address in cycle n+1 after the base handshake edge. It then asserts rf_wr_en with index n and data equal to mem_rdata in the following cycle, one element per cycle with no gaps.
- R5: A store asserts rf_rd_en with index n in cycle n+1 after the base handshake edge. In the next cycle it asserts mem_wr with element n's address and data equal to rf_rd_data.
- R6: done pulses for exactly one cycle, in the cycle of the last element's write. When the element count is zero, done pulses in the second cycle after the base handshake and no access is made.
- R7: cmd_ready is low from the base handshake edge through the done cycle, so words offered meanwhile are not taken and do not disturb the running instruction. It is high again in the cycle after done.
- R8: After reset cmd_ready is high and mem_rd, mem_wr, rf_rd_en, rf_wr_en and done are all low.
- R9: A load never drives rf_rd_en or mem_wr, and a store never drives mem_rd or rf_wr_en.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command word offered |
| cmd_ready | output | 1 | Command word can be taken |
| cmd_data | input | 32 | Instruction word, then base word |
| mem_addr | output | 16 | Private bank address |
| mem_rd | output | 1 | Bank read strobe |
| mem_wr | output | 1 | Bank write strobe |
| mem_wdata | output | 32 | Bank write data |
| mem_rdata | input | 32 | Bank read data, one cycle after mem_rd |
| rf_reg | output | 8 | Register ID for register-file accesses |
| rf_rd_en | output | 1 | Register-file read strobe |
| rf_rd_idx | output | 8 | Element index being read |
| rf_rd_data | input | 32 | Register-file read data, one cycle after rf_rd_en |
| rf_wr_en | output | 1 | Register-file write strobe |
| rf_wr_idx | output | 8 | Element index being written |
| rf_wr_data | output | 32 | Register-file write data |
| done | output | 1 | Last element finished |

## Verification
Counting from the clock edge that takes the base word, element n's bank read or register read is due in cycle n+1. Its bank write or register write-back is due in cycle n+2. done is due in cycle count+1, or in cycle 2 for an empty instruction. cmd_ready returns one cycle after done. The bench numbers the cycles from that edge and samples every output at the falling edge of each numbered cycle, comparing it with the schedule derived from these offsets. It supplies each memory and register read response right after the sample in which the request appears, so the returned word is present for exactly the cycle in which it is due to be written.

// File: rtl/lsu_agu_pkg.sv
package lsu_agu_pkg;

    // Field positions in the instruction word; the capture stage decodes them.
    localparam int unsigned REG_LSB    = 0;
    localparam int unsigned STRIDE_LSB = 8;
    localparam int unsigned VLEN_LSB   = 16;
    localparam int unsigned STORE_BIT  = 31;

    typedef enum logic [1:0] {
        CAP_INSTR = 2'd0,
        CAP_BASE  = 2'd1,
        CAP_RUN   = 2'd2
    } cap_state_e;

endpackage

// File: rtl/lsu_cmd_capture.sv
module lsu_cmd_capture
    import lsu_agu_pkg::*;
#(
    parameter int unsigned WORD_W   = 32,
    parameter int unsigned ADDR_W   = 16,
    parameter int unsigned REG_W    = 8,
    parameter int unsigned STRIDE_W = 8,
    parameter int unsigned VLEN_W   = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_valid,
    output logic                cmd_ready,
    input  logic [WORD_W-1:0]   cmd_data,
    input  logic                xfer_done,
    output logic                launch,
    output logic [ADDR_W-1:0]   base,
    output logic                is_store,
    output logic [REG_W-1:0]    reg_id,
    output logic [STRIDE_W-1:0] stride,
    output logic [VLEN_W-1:0]   vlen
);

    typedef struct packed {
        cap_state_e          state;
        logic                is_store;
        logic [REG_W-1:0]    reg_id;
        logic [STRIDE_W-1:0] stride;
        logic [VLEN_W-1:0]   vlen;
    } cap_t;

    cap_t cap_d, cap_q;

    // Reserved bits of the instruction word carry no meaning.
    logic unused_cmd_bits;
    assign unused_cmd_bits = ^cmd_data[STORE_BIT-1:VLEN_LSB+VLEN_W];

    always_comb begin
        cap_d = cap_q;
        unique case (cap_q.state)
            CAP_INSTR: begin
                if (cmd_valid) begin
                    cap_d.is_store = cmd_data[STORE_BIT];
                    cap_d.reg_id   = cmd_data[REG_LSB +: REG_W];
                    cap_d.stride   = cmd_data[STRIDE_LSB +: STRIDE_W];
                    cap_d.vlen     = cmd_data[VLEN_LSB +: VLEN_W];
                    cap_d.state    = CAP_BASE;
                end
            end
            CAP_BASE: begin
                if (cmd_valid) begin
                    cap_d.state = CAP_RUN;
                end
            end
            CAP_RUN: begin
                if (xfer_done) begin
                    cap_d.state = CAP_INSTR;
                end
            end
            default: cap_d.state = CAP_INSTR;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_q <= '0;
        end else begin
            cap_q <= cap_d;
        end
    end

    assign cmd_ready = (cap_q.state != CAP_RUN);
    assign launch    = (cap_q.state == CAP_BASE) && cmd_valid;
    assign base      = cmd_data[ADDR_W-1:0];
    assign is_store  = cap_q.is_store;
    assign reg_id    = cap_q.reg_id;
    assign stride    = cap_q.stride;
    assign vlen      = cap_q.vlen;

    // R6: completion is only reported while an instruction is running
    p_done_in_run_r6: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |-> (cap_q.state == CAP_RUN));

    // R7: the held instruction fields stay fixed while it runs
    p_fields_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_q.state == CAP_RUN && $past(cap_q.state == CAP_RUN))
            |-> ($stable(cap_q.stride) && $stable(cap_q.reg_id) && $stable(cap_q.is_store)));

endmodule

// File: rtl/lsu_elem_seq.sv
module lsu_elem_seq #(
    parameter int unsigned LANES    = 4,
    parameter int unsigned ADDR_W   = 16,
    parameter int unsigned STRIDE_W = 8,
    parameter int unsigned VLEN_W   = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                launch,
    input  logic [ADDR_W-1:0]   base,
    input  logic [STRIDE_W-1:0] stride,
    input  logic [VLEN_W-1:0]   vlen,
    output logic                issue_v,
    output logic                issue_last,
    output logic [VLEN_W-1:0]   issue_idx,
    output logic [ADDR_W-1:0]   issue_addr,
    output logic                empty
);

    localparam int unsigned LANE_SH = $clog2(LANES);

    typedef struct packed {
        logic              active;
        logic              empty;
        logic [VLEN_W-1:0] remain;
        logic [VLEN_W-1:0] idx;
        logic [ADDR_W-1:0] addr;
    } seq_t;

    seq_t seq_d, seq_q;
    logic [VLEN_W-1:0] elem_cnt;

    assign elem_cnt = vlen >> LANE_SH;

    always_comb begin
        seq_d       = seq_q;
        seq_d.empty = 1'b0;
        if (launch) begin
            seq_d.active = (elem_cnt != '0);
            seq_d.empty  = (elem_cnt == '0);
            seq_d.remain = elem_cnt;
            seq_d.idx    = '0;
            seq_d.addr   = base;
        end else if (seq_q.active) begin
            seq_d.active = (seq_q.remain != VLEN_W'(1));
            seq_d.remain = seq_q.remain - VLEN_W'(1);
            seq_d.idx    = seq_q.idx + VLEN_W'(1);
            seq_d.addr   = seq_q.addr + ADDR_W'(stride);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign issue_v    = seq_q.active;
    assign issue_last = seq_q.active && (seq_q.remain == VLEN_W'(1));
    assign issue_idx  = seq_q.idx;
    assign issue_addr = seq_q.addr;
    assign empty      = seq_q.empty;

    // R7: a new instruction is only started on an idle counter
    p_launch_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        launch |-> !seq_q.active);

    // R4: back-to-back elements carry consecutive indices
    p_idx_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.active && $past(seq_q.active)) |-> (seq_q.idx == VLEN_W'($past(seq_q.idx) + 1'b1)));

    // R2: the first element of a run has index zero
    p_first_idx_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(seq_q.active) |-> (seq_q.idx == '0));

endmodule

// File: rtl/lsu_xfer_stage.sv
module lsu_xfer_stage #(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned VLEN_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue_v,
    input  logic              issue_last,
    input  logic [VLEN_W-1:0] issue_idx,
    input  logic [ADDR_W-1:0] issue_addr,
    input  logic              empty,
    output logic              c_v,
    output logic [VLEN_W-1:0] c_idx,
    output logic [ADDR_W-1:0] c_addr,
    output logic              done
);

    typedef struct packed {
        logic              v;
        logic              last;
        logic              empty;
        logic [VLEN_W-1:0] idx;
        logic [ADDR_W-1:0] addr;
    } stg_t;

    stg_t stg_d, stg_q;

    always_comb begin
        stg_d       = stg_q;
        stg_d.v     = issue_v;
        stg_d.last  = issue_last;
        stg_d.empty = empty;
        if (issue_v) begin
            stg_d.idx  = issue_idx;
            stg_d.addr = issue_addr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg_q <= '0;
        end else begin
            stg_q <= stg_d;
        end
    end

    assign c_v    = stg_q.v;
    assign c_idx  = stg_q.idx;
    assign c_addr = stg_q.addr;
    assign done   = (stg_q.v && stg_q.last) || stg_q.empty;

    // R6: done is a single-cycle pulse
    p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6: an empty instruction never produces a write
    p_empty_no_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        stg_q.empty |-> !stg_q.v);

endmodule

// File: rtl/lane_strided_agu.sv
module lane_strided_agu #(
    parameter int unsigned LANES    = 4,
    parameter int unsigned WORD_W   = 32,
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned ADDR_W   = 16,
    parameter int unsigned REG_W    = 8,
    parameter int unsigned STRIDE_W = 8,
    parameter int unsigned VLEN_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [WORD_W-1:0] cmd_data,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [REG_W-1:0]  rf_reg,
    output logic              rf_rd_en,
    output logic [VLEN_W-1:0] rf_rd_idx,
    input  logic [DATA_W-1:0] rf_rd_data,
    output logic              rf_wr_en,
    output logic [VLEN_W-1:0] rf_wr_idx,
    output logic [DATA_W-1:0] rf_wr_data,
    output logic              done
);

    logic                launch;
    logic [ADDR_W-1:0]   base;
    logic                is_store;
    logic [REG_W-1:0]    reg_id;
    logic [STRIDE_W-1:0] stride;
    logic [VLEN_W-1:0]   vlen;
    logic                issue_v;
    logic                issue_last;
    logic [VLEN_W-1:0]   issue_idx;
    logic [ADDR_W-1:0]   issue_addr;
    logic                empty;
    logic                c_v;
    logic [VLEN_W-1:0]   c_idx;
    logic [ADDR_W-1:0]   c_addr;

    lsu_cmd_capture #(
        .WORD_W(WORD_W), .ADDR_W(ADDR_W), .REG_W(REG_W),
        .STRIDE_W(STRIDE_W), .VLEN_W(VLEN_W)
    ) u_capture (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_data(cmd_data),
        .xfer_done(done), .launch(launch), .base(base),
        .is_store(is_store), .reg_id(reg_id), .stride(stride), .vlen(vlen)
    );

    lsu_elem_seq #(
        .LANES(LANES), .ADDR_W(ADDR_W), .STRIDE_W(STRIDE_W), .VLEN_W(VLEN_W)
    ) u_seq (
        .clk(clk), .rst_n(rst_n),
        .launch(launch), .base(base), .stride(stride), .vlen(vlen),
        .issue_v(issue_v), .issue_last(issue_last), .issue_idx(issue_idx),
        .issue_addr(issue_addr), .empty(empty)
    );

    lsu_xfer_stage #(
        .ADDR_W(ADDR_W), .VLEN_W(VLEN_W)
    ) u_stage (
        .clk(clk), .rst_n(rst_n),
        .issue_v(issue_v), .issue_last(issue_last), .issue_idx(issue_idx),
        .issue_addr(issue_addr), .empty(empty),
        .c_v(c_v), .c_idx(c_idx), .c_addr(c_addr), .done(done)
    );

    // Loads address the bank at issue; stores address it one cycle later.
    assign mem_addr   = is_store ? c_addr : issue_addr;
    assign mem_rd     = issue_v && !is_store;
    assign mem_wr     = c_v && is_store;
    assign mem_wdata  = rf_rd_data;
    assign rf_reg     = reg_id;
    assign rf_rd_en   = issue_v && is_store;
    assign rf_rd_idx  = issue_idx;
    assign rf_wr_en   = c_v && !is_store;
    assign rf_wr_idx  = c_idx;
    assign rf_wr_data = mem_rdata;

    // R5: every bank write is preceded by a register read
    p_wr_after_rd_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> $past(rf_rd_en));

    // R4: every write-back is preceded by a bank read
    p_wb_after_mem_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rf_wr_en |-> $past(mem_rd));

    // R9: the two directions never mix in one cycle
    p_dir_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr) && !(rf_rd_en && rf_wr_en));

    // R7: the command channel is closed while any transfer is in flight
    p_busy_closed_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd || mem_wr || rf_rd_en || rf_wr_en || done) |-> !cmd_ready);

endmodule

// File: tb/lane_strided_agu_bench.sv
module lane_strided_agu_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cmd_valid;
    logic        cmd_ready;
    logic [31:0] cmd_data;
    logic [15:0] mem_addr;
    logic        mem_rd, mem_wr;
    logic [31:0] mem_wdata, mem_rdata;
    logic [7:0]  rf_reg;
    logic        rf_rd_en;
    logic [7:0]  rf_rd_idx;
    logic [31:0] rf_rd_data;
    logic        rf_wr_en;
    logic [7:0]  rf_wr_idx;
    logic [31:0] rf_wr_data;
    logic        done;

    int n_vec = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lane_strided_agu u_lane_strided_agu (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_data(cmd_data),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .rf_reg(rf_reg), .rf_rd_en(rf_rd_en), .rf_rd_idx(rf_rd_idx),
        .rf_rd_data(rf_rd_data), .rf_wr_en(rf_wr_en), .rf_wr_idx(rf_wr_idx),
        .rf_wr_data(rf_wr_data), .done(done)
    );

    function automatic logic [31:0] mem_word(input logic [15:0] a);
        return {a ^ 16'hA55A, ~a};
    endfunction

    function automatic logic [31:0] rf_word(input logic [7:0] r, input logic [7:0] i);
        return {r, i, i ^ 8'h3C, r ^ 8'h96};
    endfunction

    function automatic logic [15:0] elem_addr(input logic [15:0] b, input logic [7:0] s, input int n);
        return b + 16'(n * int'(s));
    endfunction

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", what, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    endtask

    // One instruction; called at a falling edge with the channel idle.
    task automatic run_instr(input bit st, input logic [7:0] rg, input logic [7:0] sd,
                             input logic [7:0] vl, input logic [15:0] base,
                             input int gap, input bit noise);
        int cnt;
        int dk;
        logic [15:0] ea;
        cnt = int'(vl) / 4;
        dk  = ((cnt == 0) ? 1 : cnt) + 1;
        chk("R7 ready when idle", 32'(cmd_ready), 32'd1);
        cmd_valid = 1'b1;
        cmd_data  = {st, 7'($urandom), vl, sd, rg};
        @(negedge clk);
        for (int g = 0; g < gap; g++) begin
            cmd_valid = 1'b0;
            cmd_data  = $urandom;
            @(negedge clk);
            chk("R1 no access before base word", 32'({mem_rd, mem_wr, rf_rd_en, rf_wr_en, done}), 32'd0);
        end
        cmd_valid = 1'b1;
        cmd_data  = {16'($urandom), base};
        for (int k = 1; k <= dk + 1; k++) begin
            bit iss;
            bit cmp;
            @(negedge clk);
            iss = (k >= 1) && (k <= cnt);
            cmp = (k >= 2) && (k <= cnt + 1);
            chk("R4/R9 mem_rd", 32'(mem_rd), 32'(iss && !st));
            chk("R5/R9 rf_rd_en", 32'(rf_rd_en), 32'(iss && st));
            chk("R5/R9 mem_wr", 32'(mem_wr), 32'(cmp && st));
            chk("R4/R9 rf_wr_en", 32'(rf_wr_en), 32'(cmp && !st));
            chk("R6 done", 32'(done), 32'(k == dk));
            chk("R7 cmd_ready", 32'(cmd_ready), 32'(k > dk));
            if (iss && !st) begin
                ea = elem_addr(base, sd, k - 1);
                chk("R3 load address", 32'(mem_addr), 32'(ea));
            end
            if (iss && st) begin
                chk("R5 read index", 32'(rf_rd_idx), 32'(k - 1));
                chk("R5 read register", 32'(rf_reg), 32'(rg));
            end
            if (cmp && st) begin
                ea = elem_addr(base, sd, k - 2);
                chk("R3 store address", 32'(mem_addr), 32'(ea));
                chk("R5 store data", mem_wdata, rf_word(rg, 8'(k - 2)));
            end
            if (cmp && !st) begin
                ea = elem_addr(base, sd, k - 2);
                chk("R4 write-back index", 32'(rf_wr_idx), 32'(k - 2));
                chk("R4 write-back data", rf_wr_data, mem_word(ea));
                chk("R4 write-back register", 32'(rf_reg), 32'(rg));
            end
            // Responses for requests seen in this cycle.
            mem_rdata  = mem_rd ? mem_word(mem_addr) : 32'hDEAD_0001;
            rf_rd_data = rf_rd_en ? rf_word(rf_reg, rf_rd_idx) : 32'hDEAD_0002;
            if (k == 1) begin
                cmd_valid = noise;
                cmd_data  = $urandom;
            end
            if (k == dk) begin
                cmd_valid = 1'b0;
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n      = 1'b0;
        cmd_valid  = 1'b0;
        cmd_data   = '0;
        mem_rdata  = '0;
        rf_rd_data = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R8 reset ready", 32'(cmd_ready), 32'd1);
        chk("R8 reset strobes", 32'({mem_rd, mem_wr, rf_rd_en, rf_wr_en}), 32'd0);
        chk("R8 reset done", 32'(done), 32'd0);

        // Directed corner cases
        run_instr(1'b0, 8'd3,   8'd1,   8'd16,  16'h0100, 0, 1'b0); // R2 unit stride load
        run_instr(1'b1, 8'd9,   8'd3,   8'd20,  16'h0200, 2, 1'b1); // R5 store, noise R7
        run_instr(1'b0, 8'd4,   8'd0,   8'd8,   16'h0333, 0, 1'b1); // R3 stride zero
        run_instr(1'b1, 8'd5,   8'd2,   8'd4,   16'h0010, 1, 1'b0); // single element
        run_instr(1'b0, 8'd6,   8'd5,   8'd3,   16'h0020, 0, 1'b1); // R2 rounds to zero
        run_instr(1'b1, 8'd7,   8'd5,   8'd0,   16'h0020, 0, 1'b0); // R6 empty store
        run_instr(1'b0, 8'd8,   8'd255, 8'd40,  16'hFFF0, 0, 1'b0); // R3 wrap
        run_instr(1'b1, 8'd255, 8'd7,   8'd255, 16'hFF00, 0, 1'b1); // R2 max count

        // Random mix
        for (int t = 0; t < 40; t++) begin
            logic [7:0] sd;
            sd = 8'($urandom);
            if (t % 7 == 0) sd = 8'd0;
            if (t % 7 == 1) sd = 8'd1;
            run_instr(1'($urandom), 8'($urandom), sd, 8'($urandom), 16'($urandom),
                      int'($urandom % 3), 1'($urandom));
        end

        finished = 1'b1;
        summary();
        $finish;
    end

endmodule